// File: doc/BRIEF.md
# Carry-Aware Add/Subtract Unit

This block is the arithmetic slice of a small RISC execution stage. It pairs a combinational 32-bit adder datapath with a one-bit carry register. Each cycle it receives two register operands, a 16-bit immediate, an opcode and an issue strobe. It returns the result word at once and the value the carry register will hold after the next clock edge. Subtraction is reversed: operand B minus operand A. A per-opcode keep bit stops the carry from being written. Two compare codes fix up bit 31 so that the sign of the result orders the operands directly, one for signed and one for unsigned ordering. Three single-bit right shifts move bit 0 into the carry.

All add and subtract forms share one adder. The adder inverts operand A for the subtract forms. Its carry-in is either a constant or the stored carry. The core drives `issue` high for every cycle in which an instruction of this unit executes. The carry register changes only in those cycles.

Top module: `carry_alu`

## Requirements
- R1: For opcode values with bit 4 = 0 and bit 0 = 0 (add forms), result = A + Bop + cin, truncated to 32 bits. When bit 1 = 0, cin is 0. When bit 1 = 1, cin is the stored carry.
- R2: For opcode values with bit 4 = 0 and bit 0 = 1 (reverse subtract forms), result = Bop + ~A + cin. When bit 1 = 0, cin is 1. When bit 1 = 1, cin is the stored carry.
- R3: In the add and subtract forms, Bop is operand B when opcode bit 3 = 0. When bit 3 = 1, Bop is the 16-bit immediate sign-extended to 32 bits.
- R4: In the add and subtract forms, when `issue` = 1 and opcode bit 2 = 0, the carry register takes bit 32 of the 33-bit sum on the next rising edge. When bit 2 = 1, the carry register is left unchanged.
- R5: Opcode 0x10 (signed compare) gives B − A. If the sign bits of A and B differ, result bit 31 is replaced by B's bit 31. The carry register is unchanged.
- R6: Opcode 0x11 (unsigned compare) gives B − A. If the sign bits of A and B differ, result bit 31 is replaced by A's bit 31. The carry register is unchanged.
- R7: Opcode 0x18 shifts A right by one with bit 31 copied from A's bit 31. When issued, it loads the carry with A's bit 0.
- R8: Opcode 0x19 shifts A right by one with bit 31 taken from the stored carry. When issued, it loads the carry with A's bit 0.
- R9: Opcode 0x1A shifts A right by one with bit 31 cleared. When issued, it loads the carry with A's bit 0.
- R10: The carry register is 0 after synchronous reset. It does not change in any cycle with `issue` = 0, and `carry_next` then equals `carry_q`.
- R11: Every other opcode with bit 4 = 1 gives result 0 and leaves the carry register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the carry register |
| issue | input | 1 | High when an instruction of this unit executes this cycle |
| opcode | input | 5 | Operation select (encodings in R1–R11) |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| imm | input | 16 | Immediate, sign-extended when selected |
| result | output | 32 | Combinational result word |
| carry_next | output | 1 | Value the carry register takes after the next edge |
| carry_q | output | 1 | Current stored carry |

## Verification
The assertions check four things on every cycle. A write to the carry register lands one edge later, and the register holds whenever no write is enabled. The shift forms keep bits 30:0 equal to A shifted down by one. A compare of two operands with equal signs equals the plain difference, and the reserved codes give zero and never write the carry. Some behaviour appears only in the bench's scenarios, which check results against an independent model: the exact carry-out of 33-bit sums at the corner operands, chains of carry-in forms that consume a carry left by an earlier operation, the bit 31 fix-up when the signs differ, and sign extension of the immediate.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int WIDTH = 32;
    localparam int IMM_W = 16;
    localparam int OP_W  = 5;

    localparam logic [OP_W-1:0] OPC_CMP_S = 5'h10;
    localparam logic [OP_W-1:0] OPC_CMP_U = 5'h11;
    localparam logic [OP_W-1:0] OPC_SRA   = 5'h18;
    localparam logic [OP_W-1:0] OPC_SRC   = 5'h19;
    localparam logic [OP_W-1:0] OPC_SRL   = 5'h1A;

    typedef enum logic [1:0] {
        SH_ARITH = 2'd0,
        SH_CARRY = 2'd1,
        SH_LOGIC = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic        is_arith;
        logic        sub;
        logic        use_c;
        logic        keep;
        logic        sel_imm;
        logic        is_cmp;
        logic        cmp_signed;
        logic        is_shift;
        shift_kind_e shift_kind;
    } dec_t;

    function automatic dec_t decode(input logic [OP_W-1:0] op);
        dec_t d;
        d = '0;
        if (!op[4]) begin
            d.is_arith = 1'b1;
            d.sub      = op[0];
            d.use_c    = op[1];
            d.keep     = op[2];
            d.sel_imm  = op[3];
        end else begin
            case (op)
                OPC_CMP_S: begin d.is_cmp = 1'b1; d.cmp_signed = 1'b1; d.sub = 1'b1; end
                OPC_CMP_U: begin d.is_cmp = 1'b1; d.sub = 1'b1; end
                OPC_SRA:   begin d.is_shift = 1'b1; d.shift_kind = SH_ARITH; end
                OPC_SRC:   begin d.is_shift = 1'b1; d.shift_kind = SH_CARRY; end
                OPC_SRL:   begin d.is_shift = 1'b1; d.shift_kind = SH_LOGIC; end
                default:   d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic logic [WIDTH-1:0] sext_imm(input logic [IMM_W-1:0] i);
        return {{(WIDTH-IMM_W){i[IMM_W-1]}}, i};
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = alu_pkg::WIDTH
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int SW = W + 1;

    logic [SW-1:0] full;

    always_comb begin
        full = {1'b0, (a ^ {W{invert_a}})} + {1'b0, b} + {{(SW-1){1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[SW-1];
    end
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
    parameter int W = alu_pkg::WIDTH
) (
    input  logic [W-1:0]        a,
    input  alu_pkg::shift_kind_e kind,
    input  logic                carry_in,
    output logic [W-1:0]        res,
    output logic                carry_out
);
    logic top_bit;

    always_comb begin
        case (kind)
            alu_pkg::SH_ARITH: top_bit = a[W-1];
            alu_pkg::SH_CARRY: top_bit = carry_in;
            default:           top_bit = 1'b0;
        endcase
        res       = {top_bit, a[W-1:1]};
        carry_out = a[0];
    end
endmodule

// File: rtl/alu_carry_reg.sv
module alu_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (wr_en) q <= d;
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(d)));

    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import alu_pkg::*;
#(
    parameter int W  = alu_pkg::WIDTH,
    parameter int IW = alu_pkg::IMM_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [OP_W-1:0] opcode,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [IW-1:0]   imm,
    output logic [W-1:0]    result,
    output logic            carry_next,
    output logic            carry_q
);
    localparam int MSB = W - 1;

    dec_t        dec;
    logic [W-1:0] b_sel;
    logic [W-1:0] imm_ext;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic [W-1:0] cmp_res;
    logic         carry_val;
    logic         carry_wr;

    assign dec     = decode(opcode);
    assign imm_ext = {{(W-IW){imm[IW-1]}}, imm};
    assign b_sel   = dec.sel_imm ? imm_ext : opb;
    assign add_cin = dec.use_c ? carry_q : dec.sub;

    alu_addsub #(.W(W)) u_addsub (
        .a        (opa),
        .b        (b_sel),
        .invert_a (dec.sub),
        .cin      (add_cin),
        .sum      (add_sum),
        .cout     (add_cout)
    );

    alu_shift1 #(.W(W)) u_shift (
        .a         (opa),
        .kind      (dec.shift_kind),
        .carry_in  (carry_q),
        .res       (sh_res),
        .carry_out (sh_cout)
    );

    always_comb begin
        cmp_res = add_sum;
        if (opa[MSB] ^ opb[MSB])
            cmp_res[MSB] = dec.cmp_signed ? opb[MSB] : opa[MSB];
    end

    always_comb begin
        if (dec.is_arith)      result = add_sum;
        else if (dec.is_cmp)   result = cmp_res;
        else if (dec.is_shift) result = sh_res;
        else                   result = '0;
    end

    assign carry_val  = dec.is_shift ? sh_cout : add_cout;
    assign carry_wr   = issue & ((dec.is_arith & ~dec.keep) | dec.is_shift);
    assign carry_next = carry_wr ? carry_val : carry_q;

    alu_carry_reg u_carry (
        .clk   (clk),
        .rst   (rst),
        .wr_en (carry_wr),
        .d     (carry_val),
        .q     (carry_q)
    );

    // R7/R8/R9: low bits of every shift form are A moved down one place
    assert_shift_body_R9: assert property (@(posedge clk) disable iff (rst)
        dec.is_shift |-> (result[MSB-1:0] == opa[MSB:1]));

    // R5/R6: with equal signs no patch applies; result is the plain difference
    assert_cmp_same_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (dec.is_cmp && (opa[MSB] == opb[MSB])) |-> (result == opb - opa));

    // R5/R6: compares never touch the carry
    assert_cmp_keeps_carry_R6: assert property (@(posedge clk) disable iff (rst)
        dec.is_cmp |=> $stable(carry_q));

    // R11: unused special codes produce zero and leave the carry alone
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (opcode[4] && !dec.is_cmp && !dec.is_shift) |-> (result == '0 && carry_next == carry_q));
endmodule

// File: tb/test_carry_alu.sv
module test_carry_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [4:0]  opcode;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic [31:0] result;
    logic        carry_next, carry_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic model_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    carry_alu i_carry_alu (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
        .opa(opa), .opb(opb), .imm(imm),
        .result(result), .carry_next(carry_next), .carry_q(carry_q)
    );

    // returns {writes_carry, new_carry, result}
    function automatic logic [33:0] ref_model(input logic [4:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [15:0] i,
                                              input logic c);
        logic [32:0] s;
        logic [31:0] bb, r;
        logic        ci;
        if (!op[4]) begin
            bb = op[3] ? {{16{i[15]}}, i} : b;
            ci = op[1] ? c : op[0];
            s  = op[0] ? ({1'b0, bb} + {1'b0, ~a} + 33'(ci)) : ({1'b0, a} + {1'b0, bb} + 33'(ci));
            return {~op[2], s[32], s[31:0]};
        end
        case (op)
            5'h10, 5'h11: begin
                r = b - a;
                if (a[31] != b[31]) r[31] = op[0] ? a[31] : b[31];
                return {1'b0, 1'b0, r};
            end
            5'h18: return {1'b1, a[0], a[31], a[31:1]};
            5'h19: return {1'b1, a[0], c, a[31:1]};
            5'h1A: return {1'b1, a[0], 1'b0, a[31:1]};
            default: return {2'b00, 32'h0};
        endcase
    endfunction

    function automatic string req_tag(input logic [4:0] op);
        if (!op[4]) begin
            if (op[3]) return "R3";
            return op[0] ? "R2" : "R1";
        end
        case (op)
            5'h10: return "R5";
            5'h11: return "R6";
            5'h18: return "R7";
            5'h19: return "R8";
            5'h1A: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h imm=%h actual=%h expected=%h",
                     tag, opcode, opa, opb, imm, act, exp);
        end
    endtask

    task automatic run_op(input logic iss, input logic [4:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] i);
        logic [33:0] m;
        @(negedge clk);
        check(iss ? "R4" : "R10", {31'b0, carry_q}, {31'b0, model_c});
        issue = iss; opcode = op; opa = a; opb = b; imm = i;
        #1;
        m = ref_model(op, a, b, i, model_c);
        check(req_tag(op), result, m[31:0]);
        if (iss && m[33]) begin
            check(req_tag(op), {31'b0, carry_next}, {31'b0, m[32]});
            model_c = m[32];
        end else begin
            check(iss ? req_tag(op) : "R10", {31'b0, carry_next}, {31'b0, model_c});
        end
    endtask

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'h8000_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [4:0] pick_op(input int k);
        if (k < 16) return 5'(k);
        case (k)
            16: return 5'h10;
            17: return 5'h11;
            18: return 5'h18;
            19: return 5'h19;
            20: return 5'h1A;
            21: return 5'h13;
            default: return 5'h1F;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; issue = 1'b0; opcode = '0; opa = '0; opb = '0; imm = '0;
        model_c = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", {31'b0, carry_q}, 32'h0);

        // carry set then carry-in forms consume it (R1/R2/R4)
        run_op(1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0);
        run_op(1'b1, 5'h02, 32'h0000_0010, 32'h0000_0020, 16'h0);
        run_op(1'b1, 5'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0); // keep: carry stays 0 (R4)
        run_op(1'b1, 5'h01, 32'h0000_0005, 32'h0000_0003, 16'h0); // R2: 3-5 borrows, carry 0
        run_op(1'b1, 5'h03, 32'h0000_0001, 32'h0000_0009, 16'h0);
        run_op(1'b1, 5'h08, 32'h0000_0010, 32'h0, 16'hFFF0);      // R3 negative imm
        run_op(1'b1, 5'h0C, 32'h0000_0001, 32'h0, 16'h7FFF);      // R3 positive imm
        // issue low: no carry change (R10)
        run_op(1'b1, 5'h18, 32'h0000_0003, 32'h0, 16'h0);
        run_op(1'b0, 5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        run_op(1'b1, 5'h19, 32'h0000_0002, 32'h0, 16'h0);         // R8 pulls stored 1 into bit 31
        run_op(1'b1, 5'h1A, 32'hFFFF_FFFF, 32'h0, 16'h0);         // R9
        run_op(1'b1, 5'h10, 32'h8000_0000, 32'h0000_0001, 16'h0); // R5 mixed signs
        run_op(1'b1, 5'h11, 32'h8000_0000, 32'h0000_0001, 16'h0); // R6 mixed signs
        run_op(1'b1, 5'h15, 32'h1234_5678, 32'h1, 16'h1);         // R11

        // corner operands across every opcode
        for (int k = 0; k < 23; k++)
            for (int x = 0; x < 4; x++)
                for (int y = 0; y < 4; y++)
                    run_op(1'b1, pick_op(k), corner(x), corner(y), corner(x+y)[15:0] ^ 16'h8001);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra, rb;
            ra = ($urandom % 5 == 0) ? corner(int'($urandom % 4)) : $urandom;
            rb = ($urandom % 5 == 0) ? corner(int'($urandom % 4)) : $urandom;
            run_op(($urandom % 8) != 0, pick_op(int'($urandom % 23)), ra, rb, 16'($urandom));
        end

        // reset returns carry to 0 (R10)
        run_op(1'b1, 5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        @(negedge clk);
        issue = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; model_c = 1'b0;
        #1;
        check("R10", {31'b0, carry_q}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule